// File: doc/BRIEF.md
# ECC Fault Status Flag Register

This block keeps a two-bit record of error-correction faults seen on memory array reads. Each array read arrives with a read strobe and two per-read fault strobes from the ECC decoder: one for a corrected single-bit fault and one for an uncorrectable double-bit fault. A busy input marks the time while a program or erase command is running. A read of the array during that time returns invalid data. Such a read is recorded as a collision, and both flags rise together.

Fault events first pass through a one-cycle capture stage, so a flag appears in the register one clock after the read that caused it. A host reads the register through an 8-bit read port. The host clears flags by writing ones to them. Each flag drives its own interrupt request, and each request is gated by an enable bit that comes from a separate control register. A configuration input can suppress the reporting of single-bit faults.

Top module: `ecc_fault_status`

## Requirements
- R1: `host_rdata` carries the double-fault flag in bit 1 and the single-fault flag in bit 0. Bits 7:2 always read as 0.
- R2: An array read (`arr_rd` high) with `cmd_busy` low and `ecc_dbl` high sets the double-fault flag.
- R3: An array read with `cmd_busy` low, `ecc_dbl` low and `ecc_sgl` high sets the single-fault flag only while `ign_sgl` is 0. While `ign_sgl` is 1 it leaves both flags unchanged.
- R4: A read that is not a collision never sets both flags. If `ecc_sgl` and `ecc_dbl` are both high, only the double-fault flag is set.
- R5: An array read while `cmd_busy` is high sets both flags. This happens whatever the values of the fault strobes and `ign_sgl`.
- R6: A cycle with `host_wr` high clears each flag whose `host_wdata` bit is 1. Flags whose bit is 0 keep their value.
- R7: A fault strobe sampled at clock edge k changes the register at edge k+1. At edge k the register does not yet change.
- R8: If a captured fault and a clear of the same flag take effect at the same edge, the flag ends at 1.
- R9: `irq_sgl` equals single-fault flag AND `irq_en_sgl`. `irq_dbl` equals double-fault flag AND `irq_en_dbl`.
- R10: A synchronous reset (`rst_n` low) clears both flags and the capture stage.
- R11: Fault strobes and `cmd_busy` have no effect when `arr_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arr_rd | input | 1 | Array read taking place this cycle |
| ecc_sgl | input | 1 | Single-bit fault was detected and corrected on this read |
| ecc_dbl | input | 1 | Double-bit fault was detected on this read |
| cmd_busy | input | 1 | A program or erase command is running |
| ign_sgl | input | 1 | Suppress single-fault reporting |
| irq_en_sgl | input | 1 | Interrupt enable for the single-fault flag |
| irq_en_dbl | input | 1 | Interrupt enable for the double-fault flag |
| host_wr | input | 1 | Host write strobe (write-one-to-clear) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register read value |
| irq_sgl | output | 1 | Single-fault interrupt request |
| irq_dbl | output | 1 | Double-fault interrupt request |

## Verification
The assertions take for granted that every input is stable and known at each rising edge once reset has been released. They also assume that the fault strobes mean something only in a cycle where `arr_rd` is high. The bench drives each input only on falling edges and holds each read strobe for exactly one cycle. Between read events it returns every input to 0. A host write never coincides with an event unless a test sets this up on purpose, as the set-wins case does.

// File: rtl/ecc_flag_pkg.sv
// Package: shared constants and types for the ECC fault status register.
// Assumes two flags: double fault at bit 1, single fault at bit 0.
package ecc_flag_pkg;
    localparam int NUM_FLAGS = 2;
    localparam int SGL_BIT   = 0;
    localparam int DBL_BIT   = 1;
    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/ecc_event_decode.sv
// Module: turns one array read and its fault strobes into a set vector
// for the flags, captured in a one-cycle stage.
// Assumes the strobes are meaningful only while rd_i is high.
module ecc_event_decode
    import ecc_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rd_i,
    input  logic      sgl_i,
    input  logic      dbl_i,
    input  logic      busy_i,
    input  logic      ign_sgl_i,
    output flag_vec_t set_q
);
    flag_vec_t set_d;

    // Classify the read: collision, double fault, then single fault.
    always_comb begin
        set_d = '0;
        if (rd_i) begin
            if (busy_i) begin
                set_d = '1;
            end else if (dbl_i) begin
                set_d[DBL_BIT] = 1'b1;
            end else if (sgl_i && !ign_sgl_i) begin
                set_d[SGL_BIT] = 1'b1;
            end
        end
    end

    // Capture stage that delays the flag update by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) set_q <= '0;
        else        set_q <= set_d;
    end

    // R4: a read that is not a collision never sets both flags
    a_r4_no_double_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !busy_i) |=> (set_q != '1));

    // R5: a read during a command marks a collision
    a_r5_collision_both: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && busy_i) |=> (set_q == '1));

    // R11: without a read, nothing is captured
    a_r11_no_read_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> (set_q == '0));
endmodule

// File: rtl/ecc_flag_bit.sv
// Module: one sticky status flag with write-one-to-clear.
// Assumes that set and clear can arrive together, and then set wins.
module ecc_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold, clear on request, and let a set override the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // R8: a set that meets a clear still leaves the flag high
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R6: a flag only falls after a clear request
    a_r6_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(clr_i));
endmodule

// File: rtl/ecc_irq_gate.sv
// Module: gates each status flag with its interrupt enable.
// Assumes the enables come from a separate control register.
module ecc_irq_gate #(
    parameter int N = 2
) (
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] irq_o
);
    for (genvar g = 0; g < N; g++) begin : g_gate
        // One request per flag, raised only when the flag is enabled.
        always_comb irq_o[g] = flag_i[g] & en_i[g];
    end
endmodule

// File: rtl/ecc_fault_status.sv
// Module: top of the ECC fault status register. It decodes read events,
// holds the sticky flags, serves the host port and drives the interrupts.
// Assumes a host read is combinational and a host write is one cycle.
module ecc_fault_status
    import ecc_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arr_rd,
    input  logic              ecc_sgl,
    input  logic              ecc_dbl,
    input  logic              cmd_busy,
    input  logic              ign_sgl,
    input  logic              irq_en_sgl,
    input  logic              irq_en_dbl,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq_sgl,
    output logic              irq_dbl
);
    localparam int PAD_W = DATA_W - NUM_FLAGS;

    flag_vec_t set_vec;
    flag_vec_t clr_vec;
    flag_vec_t flags;
    flag_vec_t irq_en;
    flag_vec_t irq_vec;
    logic      unused_wdata;

    ecc_event_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_i      (arr_rd),
        .sgl_i     (ecc_sgl),
        .dbl_i     (ecc_dbl),
        .busy_i    (cmd_busy),
        .ign_sgl_i (ign_sgl),
        .set_q     (set_vec)
    );

    // Form the write-one-to-clear mask from the host write.
    always_comb clr_vec = host_wr ? host_wdata[NUM_FLAGS-1:0] : '0;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        ecc_flag_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .clr_i  (clr_vec[i]),
            .flag_o (flags[i])
        );
    end

    // Put the enables in flag-bit order.
    always_comb begin
        irq_en          = '0;
        irq_en[SGL_BIT] = irq_en_sgl;
        irq_en[DBL_BIT] = irq_en_dbl;
    end

    ecc_irq_gate #(.N(NUM_FLAGS)) u_irq (
        .flag_i (flags),
        .en_i   (irq_en),
        .irq_o  (irq_vec)
    );

    // Drive the read value and the interrupt outputs.
    always_comb begin
        host_rdata   = {{PAD_W{1'b0}}, flags};
        irq_sgl      = irq_vec[SGL_BIT];
        irq_dbl      = irq_vec[DBL_BIT];
        unused_wdata = ^host_wdata[DATA_W-1:NUM_FLAGS];
    end

    // R1: the reserved bits read as zero
    always_comb begin
        if (rst_n) a_r1_upper_zero: assert (host_rdata[DATA_W-1:NUM_FLAGS] == '0);
    end

    // R7: a flag rises exactly two samples after the read that caused it
    a_r7_dbl_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[DBL_BIT]) |-> $past(arr_rd, 2));
    a_r7_sgl_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[SGL_BIT]) |-> $past(arr_rd, 2));

    // R9: an interrupt request needs its enabled flag
    a_r9_irq_dbl_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dbl |-> (host_rdata[DBL_BIT] && irq_en_dbl));

    // R10: reset leaves both flags clear
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (host_rdata == '0));
endmodule

// File: tb/tb_ecc_fault_status.sv
`timescale 1ns/1ps
module tb_ecc_fault_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arr_rd = 0, ecc_sgl = 0, ecc_dbl = 0, cmd_busy = 0, ign_sgl = 0;
    logic       irq_en_sgl = 0, irq_en_dbl = 0, host_wr = 0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq_sgl, irq_dbl;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    ecc_fault_status dut (
        .clk(clk), .rst_n(rst_n), .arr_rd(arr_rd), .ecc_sgl(ecc_sgl),
        .ecc_dbl(ecc_dbl), .cmd_busy(cmd_busy), .ign_sgl(ign_sgl),
        .irq_en_sgl(irq_en_sgl), .irq_en_dbl(irq_en_dbl), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_sgl(irq_sgl), .irq_dbl(irq_dbl)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected flag pair for one read event, taken from the requirements.
    function automatic logic [1:0] expect_flags(logic rd, logic s, logic d, logic b, logic ig);
        if (!rd)          return 2'b00;  // R11
        if (b)            return 2'b11;  // R5
        if (d)            return 2'b10;  // R2, R4
        if (s && !ig)     return 2'b01;  // R3
        return 2'b00;
    endfunction

    task automatic host_write(input logic [7:0] d);
        @(negedge clk); host_wr = 1; host_wdata = d;
        @(negedge clk); host_wr = 0; host_wdata = '0;
    endtask

    task automatic read_event(input logic rd, input logic s, input logic d, input logic b, input logic ig);
        @(negedge clk); arr_rd = rd; ecc_sgl = s; ecc_dbl = d; cmd_busy = b; ign_sgl = ig;
        @(negedge clk); arr_rd = 0; ecc_sgl = 0; ecc_dbl = 0; cmd_busy = 0; ign_sgl = 0;
    endtask

    initial begin : watchdog
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] e;
        repeat (3) @(negedge clk);
        check("R10 reset", host_rdata, 8'h00);
        rst_n = 1;
        @(negedge clk);
        check("R10 after reset", host_rdata, 8'h00);

        // Sweep every combination of read, strobes, busy and ignore.
        for (int v = 0; v < 32; v++) begin
            host_write(8'hFF);
            check("R6 cleared before event", host_rdata, 8'h00);
            read_event(v[4], v[0], v[1], v[2], v[3]);
            check("R7 not visible at first edge", host_rdata, 8'h00);
            @(negedge clk);
            e = expect_flags(v[4], v[0], v[1], v[2], v[3]);
            check("R1 R2 R3 R4 R5 R11 flags", host_rdata, {6'b0, e});
            for (int en = 0; en < 4; en++) begin
                irq_en_sgl = en[0]; irq_en_dbl = en[1];
                #0.5;
                check("R9 irq", {6'b0, irq_dbl, irq_sgl}, {6'b0, e & en[1:0]});
            end
            irq_en_sgl = 0; irq_en_dbl = 0;
        end

        // Write-one-to-clear sweep starting from both flags set.
        for (int w = 0; w < 4; w++) begin
            host_write(8'hFF);
            read_event(1, 0, 0, 1, 0);
            @(negedge clk);
            check("R5 setup", host_rdata, 8'h03);
            host_write({6'b111111, w[1:0]});
            check("R6 w1c", host_rdata, {6'b0, ~w[1:0]});
        end

        // Writing zero changes nothing.
        host_write(8'hFF);
        read_event(1, 0, 1, 0, 0);
        @(negedge clk);
        host_write(8'h00);
        check("R6 write zero", host_rdata, 8'h02);

        // Set and clear of the same flag at the same edge: set wins.
        host_write(8'hFF);
        @(negedge clk); arr_rd = 1; ecc_sgl = 1;
        @(negedge clk); arr_rd = 0; ecc_sgl = 0; host_wr = 1; host_wdata = 8'h01;
        @(negedge clk); host_wr = 0; host_wdata = '0;
        check("R8 set wins", host_rdata, 8'h01);

        // Reset clears live flags.
        read_event(1, 0, 0, 1, 0);
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        check("R10 reset clears", host_rdata, 8'h00);
        rst_n = 1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule